// File: doc/BRIEF.md
# Host-Side Mailbox Ring Register Interface

This block is the host's register view of a two-way message mailbox built from 32-bit slots. The host writes one slot at a time into an outbound window, and each write feeds the host-to-device ring. It reads one slot at a time from an inbound window, and each read drains the device-to-host ring. Two status words report ring occupancy. Each word holds free-running 8-bit read and write pointers and the ring depth in slots, so software computes the fill level as the 8-bit difference of the pointers. The same words carry the interrupt, ready and reset handshake bits.

A small stub port stands in for the device. Through it the device consumes host slots, produces inbound slots, raises a notify event and reports that it is ready. The port also returns a one-cycle kick pulse and a ring-reset indication to the device. A separate idle control register runs a wake handshake. The device counts as active only after the host has cleared the idle request and the device has then reported command-in-progress.

Two state machines control the block.

The link machine has two states, RUN and RESET:
- RUN goes to RESET on a status-word write that sets both the reset bit and the interrupt-generate bit. Both rings are emptied and the device ready flag drops.
- RESET goes back to RUN on a status-word write whose reset bit is 0.

The idle machine has three states, IDLE, WAKE and ACTIVE:
- IDLE goes to WAKE on an idle-register write with the idle bit 0.
- WAKE goes to ACTIVE when command-in-progress is high.
- WAKE and ACTIVE go back to IDLE on an idle-register write with the idle bit 1.

Top module: `mbox_regif`

## Requirements
- R1: Address decode and read timing.
  - Registers sit at these byte addresses:
    - 0x000: outbound window, write-only; reads return 0.
    - 0x004: host status.
    - 0x008: inbound window.
    - 0x00C: device status, read-only.
    - 0x800: idle control.
  - Read data appears on `bus_rdata` one clock after the read request.
  - A read of any other address returns 0.
- R2: Host status word layout.
  - Bit 0: interrupt enable, read/write.
  - Bit 1: interrupt status.
  - Bit 2: interrupt generate; always reads 0.
  - Bit 3: host ready, read/write.
  - Bit 4: reset, read/write.
  - Bit 5: overflow.
  - Bits 15:8: host-to-device read pointer.
  - Bits 23:16: host-to-device write pointer.
  - Bits 31:24: DEPTH.
  - After reset the word reads DEPTH<<24.
- R3: A write to 0x000 pushes one slot into the host-to-device ring. A write while that ring holds DEPTH slots is dropped and sets overflow (bit 5). Overflow stays set until the host writes 1 to bit 5.
- R4: A read of 0x008 returns the oldest inbound slot and advances the device-to-host read pointer by one. A read of an empty ring returns 0 and moves no pointer.
- R5: Pointers are 8-bit and free-running, and wrap modulo 256.
  - The fill level is (write pointer - read pointer) mod 256.
  - The free space of the host ring is DEPTH minus the fill level.
- R6: Interrupt status and interrupt output.
  - A `dev_notify` pulse sets interrupt status. The set wins over a clear in the same cycle.
  - Writing 1 to bit 1 clears interrupt status.
  - `host_irq` is high exactly when interrupt enable and interrupt status are both 1.
- R7: Writing 1 to bit 2 of the host status word gives a `dev_kick` pulse one cycle wide, in the cycle after the write.
- R8: Reset handshake.
  - A host status write with bits 4 and 2 both set, made in RUN, enters RESET.
    - Both rings' pointers become 0 and the device ready flag clears.
    - `ring_reset` goes high.
    - Outbound-window writes, inbound-window reads, device pushes and device pops have no effect while in RESET.
  - Setting bit 4 without bit 2 starts nothing.
  - A host status write with bit 4 at 0 returns the link to RUN.
- R9: Device status word layout.
  - Bit 3: device ready. A `dev_ready_set` pulse sets it, and it stays set until the next reset entry.
  - Bits 15:8: device-to-host read pointer.
  - Bits 23:16: device-to-host write pointer.
  - Bits 31:24: DEPTH.
- R10: Idle control register.
  - Bit 2 is the idle request. It reads 1 only in IDLE, which is the state after reset.
  - Bit 0 reads the live `dev_cip` input.
  - `dev_active` rises only after the idle bit has been written 0 and `dev_cip` has then been seen high.
- R11: Device stub port.
  - `dev_pop_data` shows the oldest outbound slot, or 0 when the outbound ring is empty.
  - A `dev_pop` pulse consumes one slot; slots come out in the order they were written.
  - A `dev_push` pulse to a full inbound ring is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| host_irq | output | 1 | Host interrupt |
| dev_push | input | 1 | Device pushes one inbound slot |
| dev_push_data | input | 32 | Inbound slot data |
| dev_pop | input | 1 | Device consumes one outbound slot |
| dev_pop_data | output | 32 | Oldest outbound slot, 0 when empty |
| dev_notify | input | 1 | Device event that sets interrupt status |
| dev_ready_set | input | 1 | Device reports ready |
| dev_cip | input | 1 | Device command-in-progress |
| dev_kick | output | 1 | Interrupt-generate pulse to the device |
| ring_reset | output | 1 | High while the link is in RESET |
| dev_active | output | 1 | Device awake after the idle handshake |

## Verification
The assertions assume that the register bus never issues two interrupt-generate writes in adjacent cycles. They also assume that `dev_push` and `dev_pop` are one-cycle pulses. The directed tasks keep to this by making each access last a single cycle, followed by a cycle with no request. All inputs change on the falling edge, so every transition of both state machines is taken from stable values.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [11:0] A_H2D_WIN  = 12'h000;
    localparam logic [11:0] A_HOST_CSR = 12'h004;
    localparam logic [11:0] A_D2H_WIN  = 12'h008;
    localparam logic [11:0] A_DEV_CSR  = 12'h00C;
    localparam logic [11:0] A_IDLE     = 12'h800;

    localparam int B_IE  = 0;
    localparam int B_IS  = 1;
    localparam int B_IG  = 2;
    localparam int B_RDY = 3;
    localparam int B_RST = 4;
    localparam int B_OVF = 5;
    localparam int B_IDLE_REQ = 2;

    typedef enum logic {L_RUN, L_RESET} link_state_t;
    typedef enum logic [1:0] {I_IDLE, I_WAKE, I_ACTIVE} idle_state_t;
endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [7:0]       rd_ptr,
    output logic [7:0]       wr_ptr,
    output logic [7:0]       filled,
    output logic             full
);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic empty, do_push, do_pop;

    assign filled  = wr_ptr - rd_ptr;
    assign full    = (filled == DEPTH_B);
    assign empty   = (filled == 8'd0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 8'd1;
            if (do_pop)  rd_ptr <= rd_ptr + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[IDXW-1:0]] <= push_data;
    end

    assign pop_data = empty ? '0 : mem[rd_ptr[IDXW-1:0]];

    // R3: occupancy never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        filled <= DEPTH_B);
    // R3: a push into a full ring leaves the write pointer alone
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> $stable(wr_ptr));
    // R4: popping an empty ring leaves the read pointer alone
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !clr) |=> $stable(rd_ptr));
    // R8: clearing zeroes both pointers
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_ptr == 8'd0 && wr_ptr == 8'd0));
endmodule

// File: rtl/mbox_idle_ctl.sv
module mbox_idle_ctl
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_idle,
    input  logic cip,
    output logic idle_bit,
    output logic active
);
    idle_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            I_IDLE:   if (wr_en && !wr_idle) st_nx = I_WAKE;
            I_WAKE:   if (wr_en && wr_idle) st_nx = I_IDLE;
                      else if (cip)         st_nx = I_ACTIVE;
            I_ACTIVE: if (wr_en && wr_idle) st_nx = I_IDLE;
            default:  st_nx = I_IDLE;
        endcase
    end

    always_comb begin
        idle_bit = (st == I_IDLE);
        active   = (st == I_ACTIVE);
    end

    // R10: activity only follows a seen command-in-progress
    p_active_needs_cip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(cip));
    // R10: an idle request always leaves the active state
    p_idle_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idle) |=> idle_bit);
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        host_irq,
    input  logic        dev_push,
    input  logic [31:0] dev_push_data,
    input  logic        dev_pop,
    output logic [31:0] dev_pop_data,
    input  logic        dev_notify,
    input  logic        dev_ready_set,
    input  logic        dev_cip,
    output logic        dev_kick,
    output logic        ring_reset,
    output logic        dev_active
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    link_state_t link, link_nx;
    logic ie, irq_st, hrdy, rst_bit, ovf, dev_rdy, kick_q;
    logic [31:0] rd_val, rdata_q;
    logic hcsr_we, h2d_we, d2h_re, idle_we, rd_req, running;
    logic reset_start, reset_end;
    logic [7:0] h2d_rp, h2d_wp, h2d_fill, d2h_rp, d2h_wp, d2h_fill;
    logic h2d_full, d2h_full, idle_bit;
    logic [31:0] d2h_data;

    assign running = (link == L_RUN);
    assign rd_req  = bus_sel && !bus_wr;
    assign hcsr_we = bus_sel && bus_wr && (bus_addr == A_HOST_CSR);
    assign h2d_we  = bus_sel && bus_wr && (bus_addr == A_H2D_WIN);
    assign idle_we = bus_sel && bus_wr && (bus_addr == A_IDLE);
    assign d2h_re  = rd_req && (bus_addr == A_D2H_WIN);
    assign reset_start = hcsr_we && bus_wdata[B_RST] && bus_wdata[B_IG] && running;
    assign reset_end   = hcsr_we && !bus_wdata[B_RST] && !running;

    mbox_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_h2d (
        .clk(clk), .rst_n(rst_n), .clr(reset_start),
        .push(h2d_we && running), .push_data(bus_wdata),
        .pop(dev_pop && running), .pop_data(dev_pop_data),
        .rd_ptr(h2d_rp), .wr_ptr(h2d_wp), .filled(h2d_fill), .full(h2d_full));

    mbox_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_d2h (
        .clk(clk), .rst_n(rst_n), .clr(reset_start),
        .push(dev_push && running), .push_data(dev_push_data),
        .pop(d2h_re && running), .pop_data(d2h_data),
        .rd_ptr(d2h_rp), .wr_ptr(d2h_wp), .filled(d2h_fill), .full(d2h_full));

    mbox_idle_ctl u_idle (
        .clk(clk), .rst_n(rst_n), .wr_en(idle_we), .wr_idle(bus_wdata[B_IDLE_REQ]),
        .cip(dev_cip), .idle_bit(idle_bit), .active(dev_active));

    // link state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link <= L_RUN;
        else        link <= link_nx;
    end

    always_comb begin
        link_nx = link;
        unique case (link)
            L_RUN:   if (reset_start) link_nx = L_RESET;
            L_RESET: if (reset_end)   link_nx = L_RUN;
            default: link_nx = L_RUN;
        endcase
    end

    // link outputs
    always_comb begin
        ring_reset = (link == L_RESET);
        host_irq   = ie && irq_st;
        dev_kick   = kick_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie <= 1'b0; irq_st <= 1'b0; hrdy <= 1'b0; rst_bit <= 1'b0;
            ovf <= 1'b0; dev_rdy <= 1'b0; kick_q <= 1'b0;
        end else begin
            kick_q <= hcsr_we && bus_wdata[B_IG];
            if (hcsr_we) begin
                ie      <= bus_wdata[B_IE];
                hrdy    <= bus_wdata[B_RDY];
                rst_bit <= bus_wdata[B_RST];
            end
            if (dev_notify)                        irq_st <= 1'b1;
            else if (hcsr_we && bus_wdata[B_IS])   irq_st <= 1'b0;
            if (h2d_we && running && h2d_full)     ovf <= 1'b1;
            else if (hcsr_we && bus_wdata[B_OVF])  ovf <= 1'b0;
            if (reset_start)                       dev_rdy <= 1'b0;
            else if (dev_ready_set)                dev_rdy <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            A_HOST_CSR: rd_val = {DEPTH_B, h2d_wp, h2d_rp, 2'b00, ovf, rst_bit,
                                  hrdy, 1'b0, irq_st, ie};
            A_D2H_WIN:  rd_val = running ? d2h_data : 32'd0;
            A_DEV_CSR:  rd_val = {DEPTH_B, d2h_wp, d2h_rp, 4'b0000, dev_rdy, 3'b000};
            A_IDLE:     rd_val = {29'd0, idle_bit, 1'b0, dev_cip};
            default:    rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_val;
    end
    assign bus_rdata = rdata_q;

    // R7: interrupt generate is a single-cycle pulse
    p_kick_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_kick |=> !dev_kick);
    // R8: entering reset drops the device ready flag
    p_reset_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_reset) |-> !dev_rdy);
    // R6: interrupt status rises only after a device notify
    p_irq_needs_notify_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_st) |-> $past(dev_notify));
    // R3: overflow is sticky until written one
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(hcsr_we && bus_wdata[B_OVF])) |=> ovf);
    // R11: a push into a full inbound ring is dropped
    p_d2h_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_full && dev_push && running && !reset_start) |=> $stable(d2h_fill));
endmodule

// File: tb/mbox_regif_test.sv
module mbox_regif_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_irq;
    logic        dev_push = 1'b0;
    logic [31:0] dev_push_data = '0;
    logic        dev_pop = 1'b0;
    logic [31:0] dev_pop_data;
    logic        dev_notify = 1'b0, dev_ready_set = 1'b0, dev_cip = 1'b0;
    logic        dev_kick, ring_reset, dev_active;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] m_hwp = 0, m_hrp = 0, m_dwp = 0, m_drp = 0;

    always #4 clk = ~clk;

    mbox_regif #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_irq(host_irq), .dev_push(dev_push), .dev_push_data(dev_push_data),
        .dev_pop(dev_pop), .dev_pop_data(dev_pop_data), .dev_notify(dev_notify),
        .dev_ready_set(dev_ready_set), .dev_cip(dev_cip), .dev_kick(dev_kick),
        .ring_reset(ring_reset), .dev_active(dev_active));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); d = bus_rdata; bus_sel = 0;
    endtask

    task automatic dpush(input logic [31:0] d);
        @(negedge clk); dev_push = 1; dev_push_data = d;
        @(negedge clk); dev_push = 0;
    endtask

    task automatic dpop(output logic [31:0] d);
        @(negedge clk); d = dev_pop_data; dev_pop = 1;
        @(negedge clk); dev_pop = 0;
    endtask

    function automatic logic [31:0] hcsr_ptrs();
        return {8'(DEPTH), m_hwp, m_hrp, 8'h00};
    endfunction

    task automatic t_reset_state();
        logic [31:0] v;
        brd(12'h004, v); check("R2 reset host word", v, {8'(DEPTH), 24'h0});
        brd(12'h00C, v); check("R9 reset device word", v, {8'(DEPTH), 24'h0});
        brd(12'h800, v); check("R10 reset idle reg", v, 32'h4);
        brd(12'h010, v); check("R1 unmapped read", v, 32'h0);
        brd(12'h000, v); check("R1 write window reads 0", v, 32'h0);
        check("R6 irq after reset", {31'd0, host_irq}, 32'd0);
    endtask

    task automatic t_outbound_basic();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) begin bwr(12'h000, 32'h1000 + i); m_hwp++; end
        brd(12'h004, v); check("R3 push moves write ptr", v, hcsr_ptrs());
        check("R5 empty slots", {24'd0, 8'(DEPTH) - (v[23:16] - v[15:8])}, DEPTH - 3);
        for (int i = 0; i < 3; i++) begin
            dpop(v); m_hrp++; check("R11 outbound order", v, 32'h1000 + i);
        end
        brd(12'h004, v); check("R11 pop moves read ptr", v, hcsr_ptrs());
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < DEPTH; i++) begin bwr(12'h000, 32'hA0 + i); m_hwp++; end
        bwr(12'h000, 32'hDEAD);
        brd(12'h004, v); check("R3 full drop and overflow bit", v, hcsr_ptrs() | 32'h20);
        for (int i = 0; i < DEPTH; i++) begin
            dpop(v); m_hrp++; check("R3 kept slots", v, 32'hA0 + i);
        end
        check("R11 empty pop data", dev_pop_data, 32'h0);
        brd(12'h004, v); check("R3 overflow sticky", {31'd0, v[5]}, 32'd1);
        bwr(12'h004, 32'h20);
        brd(12'h004, v); check("R3 overflow write-one clear", v, hcsr_ptrs());
    endtask

    task automatic t_inbound();
        logic [31:0] v;
        dpush(32'hB0B0_0001); m_dwp++;
        dpush(32'hB0B0_0002); m_dwp++;
        brd(12'h008, v); m_drp++; check("R4 inbound first", v, 32'hB0B0_0001);
        brd(12'h008, v); m_drp++; check("R4 inbound second", v, 32'hB0B0_0002);
        brd(12'h008, v); check("R4 empty read zero", v, 32'h0);
        brd(12'h00C, v); check("R4 empty read no move", v, {8'(DEPTH), m_dwp, m_drp, 8'h00});
        for (int i = 0; i < DEPTH + 1; i++) begin
            dpush(32'hC0 + i);
            if (i < DEPTH) m_dwp++;
        end
        brd(12'h00C, v); check("R11 inbound full drop", v, {8'(DEPTH), m_dwp, m_drp, 8'h00});
        for (int i = 0; i < DEPTH; i++) begin
            brd(12'h008, v); m_drp++; check("R4 inbound drain", v, 32'hC0 + i);
        end
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        logic [7:0] fill;
        while (m_hwp != 8'd254) begin
            bwr(12'h000, 32'h0); m_hwp++;
            dpop(v); m_hrp++;
        end
        for (int i = 0; i < 5; i++) begin bwr(12'h000, 32'hE0 + i); m_hwp++; end
        brd(12'h004, v); check("R5 wrapped pointers", v, hcsr_ptrs());
        fill = v[23:16] - v[15:8];
        check("R5 filled mod 256", {24'd0, fill}, 32'd5);
        check("R5 empty after wrap", {24'd0, 8'(DEPTH) - fill}, DEPTH - 5);
        for (int i = 0; i < 5; i++) begin
            dpop(v); m_hrp++; check("R11 order across wrap", v, 32'hE0 + i);
        end
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); dev_notify = 1; @(negedge clk); dev_notify = 0;
        brd(12'h004, v); check("R6 notify sets status", {30'd0, v[1:0]}, 32'h2);
        check("R6 irq masked", {31'd0, host_irq}, 32'd0);
        bwr(12'h004, 32'h1);
        check("R6 irq enabled", {31'd0, host_irq}, 32'd1);
        bwr(12'h004, 32'h3);
        check("R6 write-one clear", {31'd0, host_irq}, 32'd0);
        bwr(12'h004, 32'h0);
    endtask

    task automatic t_kick();
        logic [31:0] v;
        check("R7 kick idle", {31'd0, dev_kick}, 32'd0);
        bwr(12'h004, 32'h4);
        check("R7 kick pulse", {31'd0, dev_kick}, 32'd1);
        @(negedge clk);
        check("R7 kick one cycle", {31'd0, dev_kick}, 32'd0);
        brd(12'h004, v); check("R2 generate bit reads 0", {31'd0, v[2]}, 32'd0);
    endtask

    task automatic t_reset_handshake();
        logic [31:0] v;
        bwr(12'h000, 32'h55); m_hwp++;
        dpush(32'h66); m_dwp++;
        @(negedge clk); dev_ready_set = 1; @(negedge clk); dev_ready_set = 0;
        brd(12'h00C, v); check("R9 device ready set", {31'd0, v[3]}, 32'd1);
        bwr(12'h004, 32'h10);
        check("R8 reset bit alone no reset", {31'd0, ring_reset}, 32'd0);
        brd(12'h004, v); check("R8 reset bit alone keeps ptrs", v, hcsr_ptrs() | 32'h10);
        bwr(12'h004, 32'h14);
        m_hwp = 0; m_hrp = 0; m_dwp = 0; m_drp = 0;
        check("R8 reset entered", {31'd0, ring_reset}, 32'd1);
        brd(12'h004, v); check("R8 host ptrs zero", v, hcsr_ptrs() | 32'h10);
        brd(12'h00C, v); check("R8 device ready cleared", v, {8'(DEPTH), 24'h0});
        dpush(32'h77); bwr(12'h000, 32'h88);
        brd(12'h00C, v); check("R8 device push ignored", v, {8'(DEPTH), 24'h0});
        brd(12'h004, v); check("R8 window write ignored", v, hcsr_ptrs() | 32'h10);
        @(negedge clk); dev_ready_set = 1; @(negedge clk); dev_ready_set = 0;
        brd(12'h00C, v); check("R9 ready after reset", v, {8'(DEPTH), 24'h8});
        bwr(12'h004, 32'h0C);
        check("R8 reset left", {31'd0, ring_reset}, 32'd0);
        brd(12'h004, v); check("R8 host ready set", v, hcsr_ptrs() | 32'h08);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        bwr(12'h800, 32'h0);
        brd(12'h800, v); check("R10 idle bit cleared", v, 32'h0);
        check("R10 not active before cip", {31'd0, dev_active}, 32'd0);
        @(negedge clk); dev_cip = 1;
        @(negedge clk);
        check("R10 active after cip", {31'd0, dev_active}, 32'd1);
        brd(12'h800, v); check("R10 cip readback", v, 32'h1);
        dev_cip = 0;
        bwr(12'h800, 32'h4);
        check("R10 back to idle", {31'd0, dev_active}, 32'd0);
        brd(12'h800, v); check("R10 idle readback", v, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_outbound_basic();
        t_overflow();
        t_inbound();
        t_wrap();
        t_irq();
        t_kick();
        t_reset_handshake();
        t_idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule